// File: doc/BRIEF.md
# Fused multiply-add NaN selector

This block decides which NaN a single-precision fused multiply-add `a*b+c` returns when one or more of its operands is a NaN. It takes the three 32-bit operands, a flag from the multiplier front end saying that one multiplicand is infinite and the other is zero, and a policy select. From these it produces a 2-bit pick code (operand a, b, c or the generated default NaN), the 32-bit NaN result, and the invalid-operation flag.

Operands are classified with a run-time polarity input. This input states whether a set fraction MSB marks a quiet NaN or a signaling one. A signaling NaN that is picked is always made quiet before it leaves the block. A default-NaN mode input replaces whatever was picked with the generated NaN. The product and sum are computed elsewhere. All outputs are registered and appear one cycle after the request.

Top module: `fma_nan_sel`

## Requirements
- R1: An operand is a NaN when its exponent bits [30:23] are all ones and its fraction [22:0] is nonzero; infinity is not a NaN. With snan_msb_i=0 a NaN with bit 22 set is quiet and one with bit 22 clear is signaling; with snan_msb_i=1 the meanings of bit 22 swap.
- R2: valid_o is high in exactly the cycle after each cycle with in_valid_i high; after reset valid_o, res_o, sel_o and invalid_o are all zero.
- R3: sel_o codes: 0 = a, 1 = b, 2 = c, 3 = default NaN. The default NaN is 0x7FC00000 when snan_msb_i=0 and 0x7FBFFFFF when snan_msb_i=1.
- R4: Policy 0: if inf_zero_i is set and c is a quiet NaN, the result is the default NaN and invalid is raised. Otherwise the first match in this order wins: signaling c, signaling a, signaling b, quiet c, quiet a, and b as the fallback.
- R5: Policy 1 with snan_msb_i=1: inf_zero_i with any NaN operand gives the default NaN and raises invalid. Otherwise the order is signaling a, signaling b, signaling c, quiet a, quiet b, and c as the fallback.
- R6: Policy 1 with snan_msb_i=0: inf_zero_i gives c and raises invalid. Otherwise the order is signaling c, signaling a, signaling b, quiet c, quiet a, and b as the fallback.
- R7: Policy 2: inf_zero_i gives c and raises invalid. Otherwise the result is a if a is any NaN, else c if c is any NaN, else b.
- R8: Policy 3: the result is the first NaN in the order a, b, c. inf_zero_i has no effect on the pick or on invalid.
- R9: invalid_o is raised whenever any of the three operands is a signaling NaN.
- R10: A picked signaling NaN is quieted. With snan_msb_i=0, bit 22 is set and all other bits, sign included, are kept. With snan_msb_i=1, the result is replaced by the default NaN and sel_o still names the operand.
- R11: With dn_mode_i=1 the result is the default NaN and sel_o is 3. invalid_o is the same as without the mode.
- R12: If no operand is a NaN, sel_o is 3, the result is the default NaN and invalid_o is 0, whatever inf_zero_i and the policy are. This rule takes precedence over R4 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| a_i | input | 32 | Multiplicand a |
| b_i | input | 32 | Multiplicand b |
| c_i | input | 32 | Addend c |
| inf_zero_i | input | 1 | One multiplicand is infinite and the other is zero |
| policy_i | input | 2 | Propagation policy, 0 to 3 |
| snan_msb_i | input | 1 | 1: a set fraction MSB marks a signaling NaN |
| dn_mode_i | input | 1 | Force the default NaN as the result |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| res_o | output | 32 | NaN result |
| sel_o | output | 2 | Pick code |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
Each policy is driven with operand mixes that give different answers under the competing priority orders. Examples are a quiet a with a signaling b, signaling NaNs in all three positions, and a single NaN among ordinary numbers, so any swap of two priority levels shows up as a different sel_o. The operand payloads are distinct (a ends in A0, b in B0, c in C0 with its sign set), so res_o shows which operand was passed through and whether the quieting kept the sign and payload. Other cases cover infinity-times-zero with a quiet or signaling addend, both polarities (including a bit pattern that is quiet under one and signaling under the other), default-NaN mode, and inputs with no NaN. These separate the inf-times-zero outcomes of the policies from one another and from the no-NaN rule.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;
  typedef enum logic [1:0] {
    POL_CFIRST = 2'd0,
    POL_SPLIT  = 2'd1,
    POL_AFIRST = 2'd2,
    POL_ABC    = 2'd3
  } policy_e;

  localparam logic [1:0] SEL_A  = 2'd0;
  localparam logic [1:0] SEL_B  = 2'd1;
  localparam logic [1:0] SEL_C  = 2'd2;
  localparam logic [1:0] SEL_DN = 2'd3;

  typedef struct packed {
    logic nan;
    logic snan;
    logic qnan;
  } nan_cls_t;
endpackage

// File: rtl/fma_nan_classify.sv
module fma_nan_classify
  import fma_nan_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op_i,
  input  logic         snan_msb_i,
  output nan_cls_t     cls_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             is_nan;

  assign exp_f  = op_i[W-2 -: EXP_W];
  assign man_f  = op_i[MAN_W-1:0];
  assign is_nan = (&exp_f) && (|man_f);

  always_comb begin
    cls_o.nan  = is_nan;
    cls_o.snan = is_nan && (man_f[MAN_W-1] == snan_msb_i);
    cls_o.qnan = is_nan && (man_f[MAN_W-1] != snan_msb_i);
  end
endmodule

// File: rtl/fma_nan_pick.sv
module fma_nan_pick
  import fma_nan_pkg::*;
(
  input  nan_cls_t   cls_a_i,
  input  nan_cls_t   cls_b_i,
  input  nan_cls_t   cls_c_i,
  input  logic       inf_zero_i,
  input  logic [1:0] policy_i,
  input  logic       snan_msb_i,
  output logic [1:0] sel_o,
  output logic       invalid_o
);
  logic any_nan, any_snan, iz_inv;
  policy_e pol;

  assign pol      = policy_e'(policy_i);
  assign any_nan  = cls_a_i.nan | cls_b_i.nan | cls_c_i.nan;
  assign any_snan = cls_a_i.snan | cls_b_i.snan | cls_c_i.snan;

  always_comb begin
    sel_o  = SEL_DN;
    iz_inv = 1'b0;
    if (any_nan) begin
      unique case (pol)
        POL_CFIRST: begin
          if (inf_zero_i && cls_c_i.qnan) begin
            sel_o  = SEL_DN;
            iz_inv = 1'b1;
          end
          else if (cls_c_i.snan) sel_o = SEL_C;
          else if (cls_a_i.snan) sel_o = SEL_A;
          else if (cls_b_i.snan) sel_o = SEL_B;
          else if (cls_c_i.qnan) sel_o = SEL_C;
          else if (cls_a_i.qnan) sel_o = SEL_A;
          else                   sel_o = SEL_B;
        end
        POL_SPLIT: begin
          if (snan_msb_i) begin
            if (inf_zero_i) begin
              sel_o  = SEL_DN;
              iz_inv = 1'b1;
            end
            else if (cls_a_i.snan) sel_o = SEL_A;
            else if (cls_b_i.snan) sel_o = SEL_B;
            else if (cls_c_i.snan) sel_o = SEL_C;
            else if (cls_a_i.qnan) sel_o = SEL_A;
            else if (cls_b_i.qnan) sel_o = SEL_B;
            else                   sel_o = SEL_C;
          end else begin
            if (inf_zero_i) begin
              sel_o  = SEL_C;
              iz_inv = 1'b1;
            end
            else if (cls_c_i.snan) sel_o = SEL_C;
            else if (cls_a_i.snan) sel_o = SEL_A;
            else if (cls_b_i.snan) sel_o = SEL_B;
            else if (cls_c_i.qnan) sel_o = SEL_C;
            else if (cls_a_i.qnan) sel_o = SEL_A;
            else                   sel_o = SEL_B;
          end
        end
        POL_AFIRST: begin
          if (inf_zero_i) begin
            sel_o  = SEL_C;
            iz_inv = 1'b1;
          end
          else if (cls_a_i.nan) sel_o = SEL_A;
          else if (cls_c_i.nan) sel_o = SEL_C;
          else                  sel_o = SEL_B;
        end
        default: begin
          if (cls_a_i.nan)      sel_o = SEL_A;
          else if (cls_b_i.nan) sel_o = SEL_B;
          else                  sel_o = SEL_C;
        end
      endcase
    end
  end

  assign invalid_o = any_snan | iz_inv;

  always_comb begin
    if (!any_nan) assert (sel_o == SEL_DN && !iz_inv);
  end
endmodule

// File: rtl/fma_nan_quiet.sv
module fma_nan_quiet
  import fma_nan_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  nan_cls_t     cls_a_i,
  input  nan_cls_t     cls_b_i,
  input  nan_cls_t     cls_c_i,
  input  logic [1:0]   sel_i,
  input  logic         snan_msb_i,
  input  logic         dn_mode_i,
  output logic [W-1:0] res_o,
  output logic [1:0]   sel_o
);
  logic [W-1:0] dflt_nan, pick;
  logic         pick_snan;

  always_comb begin
    dflt_nan = '0;
    dflt_nan[W-2 -: EXP_W] = '1;
    if (snan_msb_i) dflt_nan[MAN_W-2:0] = '1;
    else            dflt_nan[MAN_W-1]   = 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      SEL_A:   begin pick = a_i; pick_snan = cls_a_i.snan; end
      SEL_B:   begin pick = b_i; pick_snan = cls_b_i.snan; end
      SEL_C:   begin pick = c_i; pick_snan = cls_c_i.snan; end
      default: begin pick = dflt_nan; pick_snan = 1'b0; end
    endcase
  end

  always_comb begin
    res_o = pick;
    sel_o = sel_i;
    if (pick_snan) begin
      if (snan_msb_i) res_o = dflt_nan;
      else            res_o[MAN_W-1] = 1'b1;
    end
    if (dn_mode_i) begin
      res_o = dflt_nan;
      sel_o = SEL_DN;
    end
  end
endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
  import fma_nan_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic         inf_zero_i,
  input  logic [1:0]   policy_i,
  input  logic         snan_msb_i,
  input  logic         dn_mode_i,
  output logic         valid_o,
  output logic [W-1:0] res_o,
  output logic [1:0]   sel_o,
  output logic         invalid_o
);
  nan_cls_t     cls [3];
  logic [W-1:0] ops [3];
  logic [1:0]   pick_sel, fin_sel;
  logic         pick_inv;
  logic [W-1:0] fin_res;
  logic         any_snan_w, any_nan_w;

  assign ops[0] = a_i;
  assign ops[1] = b_i;
  assign ops[2] = c_i;

  for (genvar g = 0; g < 3; g++) begin : g_cls
    fma_nan_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i       (ops[g]),
      .snan_msb_i (snan_msb_i),
      .cls_o      (cls[g])
    );
  end

  assign any_snan_w = cls[0].snan | cls[1].snan | cls[2].snan;
  assign any_nan_w  = cls[0].nan  | cls[1].nan  | cls[2].nan;

  fma_nan_pick u_pick (
    .cls_a_i    (cls[0]),
    .cls_b_i    (cls[1]),
    .cls_c_i    (cls[2]),
    .inf_zero_i (inf_zero_i),
    .policy_i   (policy_i),
    .snan_msb_i (snan_msb_i),
    .sel_o      (pick_sel),
    .invalid_o  (pick_inv)
  );

  fma_nan_quiet #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_quiet (
    .a_i        (a_i),
    .b_i        (b_i),
    .c_i        (c_i),
    .cls_a_i    (cls[0]),
    .cls_b_i    (cls[1]),
    .cls_c_i    (cls[2]),
    .sel_i      (pick_sel),
    .snan_msb_i (snan_msb_i),
    .dn_mode_i  (dn_mode_i),
    .res_o      (fin_res),
    .sel_o      (fin_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      res_o     <= '0;
      sel_o     <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= in_valid_i;
      if (in_valid_i) begin
        res_o     <= fin_res;
        sel_o     <= fin_sel;
        invalid_o <= pick_inv;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(in_valid_i));

  p_snan_invalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && any_snan_w) |=> invalid_o);

  p_dn_mode_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && dn_mode_i) |=> (sel_o == SEL_DN));

  p_no_nan_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !any_nan_w) |=> (sel_o == SEL_DN && !invalid_o));

  p_quiet_out_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i) |=> ((&res_o[W-2 -: EXP_W]) && (res_o[MAN_W-1] != $past(snan_msb_i))));
endmodule

// File: tb/fma_nan_sel_tb_top.sv
`timescale 1ns/1ps
module fma_nan_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] a = '0, b = '0, c = '0;
  logic        iz = 1'b0;
  logic [1:0]  pol = '0;
  logic        msb = 1'b0;
  logic        dn = 1'b0;
  logic        valid;
  logic [31:0] res;
  logic [1:0]  sel;
  logic        inv;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  localparam logic [31:0] NUM  = 32'h3F80_0000;
  localparam logic [31:0] INF  = 32'h7F80_0000;
  localparam logic [31:0] ZERO = 32'h0000_0000;
  localparam logic [31:0] DN0  = 32'h7FC0_0000;
  localparam logic [31:0] DN1  = 32'h7FBF_FFFF;
  // polarity 0 patterns
  localparam logic [31:0] QA0 = 32'h7FC0_00A0, SA0 = 32'h7F80_00A0;
  localparam logic [31:0] QB0 = 32'h7FC0_00B0, SB0 = 32'h7F80_00B0;
  localparam logic [31:0] QC0 = 32'hFFC0_00C0, SC0 = 32'hFF80_00C0;
  // polarity 1 patterns
  localparam logic [31:0] QA1 = 32'h7F80_00A0, SA1 = 32'h7FC0_00A0;
  localparam logic [31:0] QB1 = 32'h7F80_00B0, SB1 = 32'h7FC0_00B0;
  localparam logic [31:0] QC1 = 32'hFF80_00C0, SC1 = 32'hFFC0_00C0;

  always #5 clk = ~clk;

  fma_nan_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .a_i(a), .b_i(b), .c_i(c), .inf_zero_i(iz), .policy_i(pol),
    .snan_msb_i(msb), .dn_mode_i(dn),
    .valid_o(valid), .res_o(res), .sel_o(sel), .invalid_o(inv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [31:0] ta, input logic [31:0] tb,
                     input logic [31:0] tc, input logic tiz, input logic [1:0] tpol,
                     input logic tmsb, input logic tdn,
                     input logic [1:0] esel, input logic [31:0] eres, input logic einv);
    @(negedge clk);
    a = ta; b = tb; c = tc; iz = tiz; pol = tpol; msb = tmsb; dn = tdn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'd0, valid}, 32'd1);
    chk({req, " sel"}, {30'd0, sel}, {30'd0, esel});
    chk({req, " res"}, res, eres);
    chk({req, " invalid"}, {31'd0, inv}, {31'd0, einv});
  endtask

  task automatic t_reset;
    chk("R2 reset valid", {31'd0, valid}, 32'd0);
    chk("R2 reset res", res, 32'd0);
    chk("R2 reset sel/inv", {29'd0, sel, inv}, 32'd0);
  endtask

  task automatic t_valid_pulse;
    run("R2 pulse", QA0, NUM, NUM, 0, 2'd3, 0, 0, 2'd0, QA0, 0);
    @(negedge clk);
    chk("R2 valid drops", {31'd0, valid}, 32'd0);
  endtask

  task automatic t_r4;
    run("R4 qa sb qc", QA0, SB0, QC0, 0, 2'd0, 0, 0, 2'd1, 32'h7FC0_00B0, 1);
    run("R4 all quiet", QA0, QB0, QC0, 0, 2'd0, 0, 0, 2'd2, QC0, 0);
    run("R4 sa sc", SA0, NUM, SC0, 0, 2'd0, 0, 0, 2'd2, 32'hFFC0_00C0, 1);
    run("R4 qa qb", QA0, QB0, NUM, 0, 2'd0, 0, 0, 2'd0, QA0, 0);
    run("R4 iz qc", INF, ZERO, QC0, 1, 2'd0, 0, 0, 2'd3, DN0, 1);
    run("R4 iz sc", ZERO, INF, SC0, 1, 2'd0, 0, 0, 2'd2, 32'hFFC0_00C0, 1);
  endtask

  task automatic t_r5;
    run("R5 qa sb sc", QA1, SB1, SC1, 0, 2'd1, 1, 0, 2'd1, DN1, 1);
    run("R5 all quiet", QA1, QB1, QC1, 0, 2'd1, 1, 0, 2'd0, QA1, 0);
    run("R5 qb qc", NUM, QB1, QC1, 0, 2'd1, 1, 0, 2'd1, QB1, 0);
    run("R5 qc only", NUM, NUM, QC1, 0, 2'd1, 1, 0, 2'd2, QC1, 0);
    run("R5 iz qc", INF, ZERO, QC1, 1, 2'd1, 1, 0, 2'd3, DN1, 1);
  endtask

  task automatic t_r6;
    run("R6 sa sb qc", SA0, SB0, QC0, 0, 2'd1, 0, 0, 2'd0, 32'h7FC0_00A0, 1);
    run("R6 qa sb qc", QA0, SB0, QC0, 0, 2'd1, 0, 0, 2'd1, 32'h7FC0_00B0, 1);
    run("R6 all quiet", QA0, QB0, QC0, 0, 2'd1, 0, 0, 2'd2, QC0, 0);
    run("R6 iz qc", INF, ZERO, QC0, 1, 2'd1, 0, 0, 2'd2, QC0, 1);
  endtask

  task automatic t_r7;
    run("R7 sb qc", NUM, SB0, QC0, 0, 2'd2, 0, 0, 2'd2, QC0, 1);
    run("R7 qa qb sc", QA0, QB0, SC0, 0, 2'd2, 0, 0, 2'd0, QA0, 1);
    run("R7 qb only", NUM, QB0, NUM, 0, 2'd2, 0, 0, 2'd1, QB0, 0);
    run("R7 iz qc", ZERO, INF, QC0, 1, 2'd2, 0, 0, 2'd2, QC0, 1);
  endtask

  task automatic t_r8;
    run("R8 qb qc", NUM, QB0, QC0, 0, 2'd3, 0, 0, 2'd1, QB0, 0);
    run("R8 R10 sc", NUM, NUM, SC0, 0, 2'd3, 0, 0, 2'd2, 32'hFFC0_00C0, 1);
    run("R8 iz no effect", INF, ZERO, QC0, 1, 2'd3, 0, 0, 2'd2, QC0, 0);
  endtask

  task automatic t_r1;
    run("R1 inf not nan", INF, QB0, NUM, 0, 2'd3, 0, 0, 2'd1, QB0, 0);
    run("R1 polarity swap", SA1, NUM, NUM, 0, 2'd3, 1, 0, 2'd0, DN1, 1);
  endtask

  task automatic t_r11;
    run("R11 dn quiet", QA0, QB0, QC0, 0, 2'd0, 0, 1, 2'd3, DN0, 0);
    run("R11 dn snan", QA0, SB0, QC0, 0, 2'd0, 0, 1, 2'd3, DN0, 1);
    run("R11 dn pol1", QA1, QB1, NUM, 0, 2'd3, 1, 1, 2'd3, DN1, 0);
  endtask

  task automatic t_r12;
    run("R12 numbers", NUM, NUM, NUM, 0, 2'd0, 0, 0, 2'd3, DN0, 0);
    run("R12 iz policy2", INF, ZERO, NUM, 1, 2'd2, 0, 0, 2'd3, DN0, 0);
    run("R12 R3 pol1", NUM, INF, ZERO, 0, 2'd1, 1, 0, 2'd3, DN1, 0);
  endtask

  initial begin
    #1;
    t_reset();
    #22 rst_n = 1'b1;
    t_valid_pulse();
    t_r4();
    t_r5();
    t_r6();
    t_r7();
    t_r8();
    t_r1();
    t_r11();
    t_r12();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule